// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer Controller

This block handles the receive side of a single non-control USB OUT endpoint at packet level. An upstream packet decoder gives it a pulse for every OUT token addressed to the endpoint, a byte stream with a per-byte strobe, and an end-of-packet strobe. The end-of-packet strobe comes with the DATA0/DATA1 PID and a flag for a CRC or bit-stuff error. The block decides whether the packet is kept. One cycle after the end-of-packet strobe, it returns the handshake that the transmitter should send: ACK, NAK, STALL or none.

Firmware sees two 8-bit control/status registers, a byte read port that always drains the oldest stored packet, and a level interrupt request. The block holds one packet, or two when double buffering is enabled, keeps the expected data toggle, and runs in either bulk/interrupt or isochronous mode. With auto-release enabled, a packet whose length equals the programmed maximum packet size is freed by the block itself as soon as its last byte has been read.

Register `ctl` (select 0): bit0 ready (read) / release-head (write 1); bit1 full (read only); bit2 iso data error (read only); bit3 overrun (write 1 to clear); bit4 stall-sent (write 1 to clear); bit5 stall request (read/write); bit6 flush (write 1, reads 0); bit7 toggle reset (write 1, reads 0). Register `cfg` (select 1): bit0 isochronous, bit1 double buffering, bit2 auto-release, bits 7:3 read 0. Handshake codes: ACK=0, NAK=1, STALL=2.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset both registers read 0x00, no handshake is issued, and the interrupt request is low.
- R2: In bulk mode, an error-free packet that follows an OUT token, whose PID matches the expected toggle, and that finds a free buffer is stored. The block returns ACK one cycle after the end-of-packet strobe, ready goes high in that same cycle, the bytes read back in arrival order with the byte count on `fifo_len`, and the expected toggle flips.
- R3: A bulk packet whose PID does not match the expected toggle is ACKed but not stored, and the toggle is left unchanged. Writing 1 to `ctl` bit7 makes the next expected packet DATA0.
- R4: A bulk packet that finds no free buffer gets NAK and is not stored. The full bit (`ctl` bit1) is 1 while one packet is held without double buffering, or while two are held with it.
- R5: A bulk packet with a CRC or bit-stuff error gets no handshake and is not stored.
- R6: While `ctl` bit5 is set in bulk mode, packets get STALL and are not stored, and `ctl` bit4 is set. Bit4 stays set until 1 is written to it. Bit5 has no effect in isochronous mode.
- R7: In isochronous mode no handshake is ever issued and the toggle is not checked. A packet with an error is still stored, `ctl` bit2 then reads 1, and the bit clears when that packet is released.
- R8: In isochronous mode, a packet arriving with no free buffer sets `ctl` bit3, which stays set until 1 is written to it.
- R9: With double buffering, two packets can be held and are read oldest first. Each flush or release write drops exactly one packet and restarts reading at byte 0 of the next one.
- R10: With auto-release on, ready clears right after the last byte of a packet of exactly the maximum packet size is read. A shorter packet stays ready after it has been fully read.
- R11: The interrupt request is high exactly when it is enabled and either ready or stall-sent is set.
- R12: An end-of-packet strobe that is not preceded by an OUT token since the last packet is ignored: no handshake, nothing stored.
- R13: `cfg` bits 7:3 and `ctl` bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_out | input | 1 | Pulse: OUT token for this endpoint |
| rx_byte_vld | input | 1 | Data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_pkt_end | input | 1 | End-of-packet strobe |
| rx_pid_odd | input | 1 | PID at end of packet: 0 DATA0, 1 DATA1 |
| rx_bad | input | 1 | CRC or bit-stuff error at end of packet |
| hs_vld | output | 1 | Handshake request valid |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| max_pkt | input | 7 | Maximum packet size in bytes |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects ctl, 1 selects cfg |
| csr_wdata | input | 8 | Register write data |
| csr_ctl | output | 8 | ctl register read value |
| csr_cfg | output | 8 | cfg register read value |
| fifo_rd | input | 1 | Pop one byte of the oldest packet |
| fifo_rdata | output | 8 | Current byte of the oldest packet |
| fifo_len | output | 7 | Byte count of the oldest packet (0 if none) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The handshake, ready, full, error and overrun results of a packet all come from the clock edge that samples the end-of-packet strobe. The bench therefore drives each strobe just after a falling edge and checks every one of these results at the next falling edge. Register writes and byte pops take effect at the edge that samples them and are read half a cycle later. This includes the auto-release after the last byte of a maximum-size packet. Expected handshakes are queued before the end-of-packet strobe is driven. A monitor compares each handshake against the queue as it appears and flags any handshake for which nothing was queued, so a spurious ACK, NAK or STALL is caught.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  // ctl register bit positions
  localparam int unsigned C_RDY    = 0;
  localparam int unsigned C_FULL   = 1;
  localparam int unsigned C_DERR   = 2;
  localparam int unsigned C_OVR    = 3;
  localparam int unsigned C_SSENT  = 4;
  localparam int unsigned C_STALL  = 5;
  localparam int unsigned C_FLUSH  = 6;
  localparam int unsigned C_TCLR   = 7;

  // cfg register bit positions
  localparam int unsigned G_ISO    = 0;
  localparam int unsigned G_DBL    = 1;
  localparam int unsigned G_ACLR   = 2;

endpackage

// File: rtl/rxep_regs.sv
module rxep_regs
  import usb_rx_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic       wr_cfg,
  input  logic [7:0] wdata,
  input  logic       set_ovr,
  input  logic       set_ssent,
  input  logic       tog_flip,
  output logic       stall_req,
  output logic       ovr,
  output logic       ssent,
  output logic       iso,
  output logic       dbl,
  output logic       aclr,
  output logic       tog_exp,
  output logic       drop_req
);

  logic stall_q, stall_d;
  logic ovr_q, ovr_d;
  logic ssent_q, ssent_d;
  logic iso_q, iso_d;
  logic dbl_q, dbl_d;
  logic aclr_q, aclr_d;
  logic tog_q, tog_d;

  always_comb begin
    stall_d = stall_q;
    iso_d   = iso_q;
    dbl_d   = dbl_q;
    aclr_d  = aclr_q;
    if (wr_ctl) stall_d = wdata[C_STALL];
    if (wr_cfg) begin
      iso_d  = wdata[G_ISO];
      dbl_d  = wdata[G_DBL];
      aclr_d = wdata[G_ACLR];
    end
    ovr_d   = set_ovr   | (ovr_q   & ~(wr_ctl & wdata[C_OVR]));
    ssent_d = set_ssent | (ssent_q & ~(wr_ctl & wdata[C_SSENT]));
    if (wr_ctl && wdata[C_TCLR]) tog_d = 1'b0;
    else if (tog_flip)           tog_d = ~tog_q;
    else                         tog_d = tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      ovr_q   <= 1'b0;
      ssent_q <= 1'b0;
      iso_q   <= 1'b0;
      dbl_q   <= 1'b0;
      aclr_q  <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      stall_q <= stall_d;
      ovr_q   <= ovr_d;
      ssent_q <= ssent_d;
      iso_q   <= iso_d;
      dbl_q   <= dbl_d;
      aclr_q  <= aclr_d;
      tog_q   <= tog_d;
    end
  end

  assign stall_req = stall_q;
  assign ovr       = ovr_q;
  assign ssent     = ssent_q;
  assign iso       = iso_q;
  assign dbl       = dbl_q;
  assign aclr      = aclr_q;
  assign tog_exp   = tog_q;
  assign drop_req  = wr_ctl & (wdata[C_FLUSH] | wdata[C_RDY]);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctl) |-> $stable(stall_req));

  // R3
  tog_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctl && wdata[C_TCLR]) |-> !tog_exp);

endmodule

// File: rtl/rxep_bufs.sv
module rxep_bufs #(
  parameter int unsigned MAXP = 64,
  localparam int unsigned LW  = $clog2(MAXP + 1),
  localparam int unsigned IW  = $clog2(MAXP),
  localparam int unsigned SLOTS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic          byte_we,
  input  logic [7:0]    byte_d,
  input  logic          commit,
  input  logic          commit_err,
  input  logic          drop,
  input  logic          dbl_en,
  input  logic          rd_pop,
  output logic [1:0]    cnt,
  output logic          room,
  output logic [LW-1:0] head_len,
  output logic          head_err,
  output logic [7:0]    rd_data,
  output logic          pop_last
);

  localparam logic [LW-1:0] CAP = LW'(MAXP);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [7:0]    mem [SLOTS*MAXP];
  logic [LW-1:0] len_q [SLOTS];
  logic [SLOTS-1:0] err_q;
  logic          head_q, head_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [LW-1:0] wr_idx_q, wr_idx_d;
  logic [LW-1:0] rd_idx_q, rd_idx_d;
  logic          wslot;
  logic          have;
  logic          pop_ok;
  logic          wr_ok;

  assign have   = (cnt_q != 2'd0);
  assign room   = (cnt_q < (dbl_en ? 2'd2 : 2'd1));
  assign wslot  = head_q ^ have;
  assign wr_ok  = byte_we && room && (wr_idx_q < CAP);
  assign pop_ok = rd_pop && have && (rd_idx_q < len_q[head_q]);

  always_comb begin
    wr_idx_d = wr_idx_q;
    if (pkt_start)  wr_idx_d = '0;
    else if (wr_ok) wr_idx_d = wr_idx_q + ONE;

    head_d   = head_q;
    cnt_d    = cnt_q;
    rd_idx_d = rd_idx_q;
    if (pop_ok) rd_idx_d = rd_idx_q + ONE;
    if (drop && have) begin
      head_d   = ~head_q;
      rd_idx_d = '0;
      cnt_d    = commit ? cnt_q : cnt_q - 2'd1;
    end else if (commit) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= 1'b0;
      cnt_q    <= 2'd0;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      head_q   <= head_d;
      cnt_q    <= cnt_d;
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
    end
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          len_q[s] <= '0;
          err_q[s] <= 1'b0;
        end else if (commit && (wslot == 1'(s))) begin
          len_q[s] <= wr_idx_q;
          err_q[s] <= commit_err;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok) mem[{wslot, wr_idx_q[IW-1:0]}] <= byte_d;
  end

  assign cnt      = cnt_q;
  assign head_len = len_q[head_q];
  assign head_err = err_q[head_q];
  assign rd_data  = mem[{head_q, rd_idx_q[IW-1:0]}];
  assign pop_last = pop_ok && ((rd_idx_q + ONE) == len_q[head_q]);

  // R9
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 2'd2);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |->
      ((cnt_q == $past(cnt_q) + 2'd1) || (cnt_q + 2'd1 == $past(cnt_q))));

  // R2
  rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> (rd_idx_q <= len_q[head_q]));

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rx_ep_pkg::*;
#(
  parameter int unsigned MAXP = 64,
  localparam int unsigned LW  = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          rx_byte_vld,
  input  logic [7:0]    rx_byte,
  input  logic          rx_pkt_end,
  input  logic          rx_pid_odd,
  input  logic          rx_bad,
  output logic          hs_vld,
  output logic [1:0]    hs_code,
  input  logic [LW-1:0] max_pkt,
  input  logic          csr_wr,
  input  logic          csr_sel,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    csr_ctl,
  output logic [7:0]    csr_cfg,
  input  logic          fifo_rd,
  output logic [7:0]    fifo_rdata,
  output logic [LW-1:0] fifo_len,
  input  logic          irq_en,
  output logic          irq
);

  logic          armed_q, armed_d;
  logic          hs_vld_q, hs_vld_d;
  hs_e           hs_code_q, hs_code_d;
  logic          stall_req, ovr, ssent, iso, dbl, aclr, tog_exp, drop_req;
  logic          set_ovr, set_ssent, tog_flip;
  logic          commit, drop;
  logic [1:0]    cnt;
  logic          room, head_err, pop_last, rdy;
  logic [LW-1:0] head_len;
  logic          judge;

  rxep_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (csr_wr & ~csr_sel),
    .wr_cfg    (csr_wr & csr_sel),
    .wdata     (csr_wdata),
    .set_ovr   (set_ovr),
    .set_ssent (set_ssent),
    .tog_flip  (tog_flip),
    .stall_req (stall_req),
    .ovr       (ovr),
    .ssent     (ssent),
    .iso       (iso),
    .dbl       (dbl),
    .aclr      (aclr),
    .tog_exp   (tog_exp),
    .drop_req  (drop_req)
  );

  rxep_bufs #(.MAXP(MAXP)) u_bufs (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_start  (tok_out),
    .byte_we    (rx_byte_vld & armed_q),
    .byte_d     (rx_byte),
    .commit     (commit),
    .commit_err (rx_bad),
    .drop       (drop),
    .dbl_en     (dbl),
    .rd_pop     (fifo_rd),
    .cnt        (cnt),
    .room       (room),
    .head_len   (head_len),
    .head_err   (head_err),
    .rd_data    (fifo_rdata),
    .pop_last   (pop_last)
  );

  assign judge = rx_pkt_end && armed_q;
  assign rdy   = (cnt != 2'd0);
  assign drop  = drop_req | (aclr && pop_last && (head_len == max_pkt));

  always_comb begin
    armed_d   = armed_q;
    if (tok_out)         armed_d = 1'b1;
    else if (rx_pkt_end) armed_d = 1'b0;

    hs_vld_d  = 1'b0;
    hs_code_d = HS_ACK;
    commit    = 1'b0;
    set_ovr   = 1'b0;
    set_ssent = 1'b0;
    tog_flip  = 1'b0;
    if (judge) begin
      if (iso) begin
        if (room) commit  = 1'b1;
        else      set_ovr = 1'b1;
      end else if (!rx_bad) begin
        hs_vld_d = 1'b1;
        if (stall_req) begin
          hs_code_d = HS_STALL;
          set_ssent = 1'b1;
        end else if (!room) begin
          hs_code_d = HS_NAK;
        end else if (rx_pid_odd == tog_exp) begin
          commit   = 1'b1;
          tog_flip = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      hs_vld_q  <= 1'b0;
      hs_code_q <= HS_ACK;
    end else begin
      armed_q   <= armed_d;
      hs_vld_q  <= hs_vld_d;
      hs_code_q <= hs_code_d;
    end
  end

  assign hs_vld   = hs_vld_q;
  assign hs_code  = hs_code_q;
  assign fifo_len = rdy ? head_len : '0;
  assign irq      = irq_en & (rdy | ssent);

  always_comb begin
    csr_ctl          = 8'h00;
    csr_ctl[C_RDY]   = rdy;
    csr_ctl[C_FULL]  = ~room;
    csr_ctl[C_DERR]  = rdy & iso & head_err;
    csr_ctl[C_OVR]   = ovr;
    csr_ctl[C_SSENT] = ssent;
    csr_ctl[C_STALL] = stall_req;
    csr_cfg          = 8'h00;
    csr_cfg[G_ISO]   = iso;
    csr_cfg[G_DBL]   = dbl;
    csr_cfg[G_ACLR]  = aclr;
  end

  // R7
  iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_end && armed_q && iso) |=> !hs_vld);

  // R6
  stall_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_end && armed_q && !iso && !rx_bad && stall_req) |=>
      (hs_vld && hs_code == 2'd2 && csr_ctl[C_SSENT]));

  // R4
  nak_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_vld && hs_code == 2'd1) |-> $past(!room));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_end && rx_bad && !iso) |=> !hs_vld);

  // R12
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_end && !armed_q && !tok_out) |=> !hs_vld);

endmodule

// File: tb/usb_rx_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_rx_ep_ctrl_test;

  localparam int unsigned MAXP = 64;
  localparam int unsigned LW   = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tok_out, rx_byte_vld, rx_pkt_end, rx_pid_odd, rx_bad;
  logic [7:0]    rx_byte;
  logic          hs_vld;
  logic [1:0]    hs_code;
  logic [LW-1:0] max_pkt;
  logic          csr_wr, csr_sel;
  logic [7:0]    csr_wdata, csr_ctl, csr_cfg, fifo_rdata;
  logic          fifo_rd, irq_en, irq;
  logic [LW-1:0] fifo_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int    exp_code[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  usb_rx_ep_ctrl #(.MAXP(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_byte_vld(rx_byte_vld),
    .rx_byte(rx_byte), .rx_pkt_end(rx_pkt_end), .rx_pid_odd(rx_pid_odd),
    .rx_bad(rx_bad), .hs_vld(hs_vld), .hs_code(hs_code), .max_pkt(max_pkt),
    .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_ctl(csr_ctl), .csr_cfg(csr_cfg), .fifo_rd(fifo_rd),
    .fifo_rdata(fifo_rdata), .fifo_len(fifo_len), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a handshake appears
  always @(negedge clk) begin
    if (rst_n && hs_vld && !done) begin
      if (exp_code.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R5/R7/R12 unexpected handshake: actual %0d expected none", hs_code);
      end else begin
        automatic int    c = exp_code.pop_front();
        automatic string t = exp_tag.pop_front();
        chk(t, int'(hs_code), c);
      end
    end
  end

  // exp: 0 ACK, 1 NAK, 2 STALL, -1 none
  task automatic send_pkt(input bit odd, input bit bad, input int n,
                          input int base, input int exp, input string tag);
    @(negedge clk); tok_out = 1'b1;
    @(negedge clk); tok_out = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_byte = 8'(base + i); rx_byte_vld = 1'b1;
      @(negedge clk);
    end
    rx_byte_vld = 1'b0;
    rx_pkt_end = 1'b1; rx_pid_odd = odd; rx_bad = bad;
    if (exp >= 0) begin exp_code.push_back(exp); exp_tag.push_back(tag); end
    @(negedge clk);
    rx_pkt_end = 1'b0; rx_bad = 1'b0;
    if (exp < 0) chk({tag, " no handshake"}, int'(hs_vld), 0);
  endtask

  task automatic wr_csr(input bit sel, input logic [7:0] d);
    csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd_byte(input int exp, input string tag);
    chk(tag, int'(fifo_rdata), exp);
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tok_out = 0; rx_byte_vld = 0; rx_byte = 0; rx_pkt_end = 0;
    rx_pid_odd = 0; rx_bad = 0; max_pkt = LW'(4); csr_wr = 0; csr_sel = 0;
    csr_wdata = 0; fifo_rd = 0; irq_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ctl", csr_ctl, 8'h00);
    chk("R1 cfg", csr_cfg, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 hs", hs_vld, 0);

    // R12: end of packet without a token
    rx_pkt_end = 1'b1; @(negedge clk); rx_pkt_end = 1'b0;
    chk("R12 hs", hs_vld, 0);
    chk("R12 ctl", csr_ctl, 8'h00);

    // R2: bulk DATA0 stored
    send_pkt(0, 0, 3, 8'h10, 0, "R2 ack");
    chk("R2 ctl rdy+full", csr_ctl, 8'h03);
    chk("R2 len", fifo_len, 3);
    chk("R11 irq on ready", irq, 1);
    rd_byte(8'h10, "R2 byte0");
    rd_byte(8'h11, "R2 byte1");
    rd_byte(8'h12, "R2 byte2");
    wr_csr(0, 8'h01);
    chk("R2 released", csr_ctl, 8'h00);
    chk("R11 irq off", irq, 0);

    // R3: toggle mismatch (expect DATA1, send DATA0)
    send_pkt(0, 0, 2, 8'h20, 0, "R3 mismatch ack");
    chk("R3 not stored", csr_ctl, 8'h00);
    send_pkt(1, 0, 2, 8'h20, 0, "R3 data1 ack");
    chk("R3 data1 stored", csr_ctl, 8'h03);
    wr_csr(0, 8'h01);
    send_pkt(0, 0, 1, 8'h30, 0, "R4 fill ack");
    // R4: full, NAK
    send_pkt(1, 0, 1, 8'h31, 1, "R4 nak");
    chk("R4 still one", fifo_len, 1);
    rd_byte(8'h30, "R4 held byte");
    wr_csr(0, 8'h01);
    // R3: toggle reset (expected is DATA1 now)
    wr_csr(0, 8'h80);
    send_pkt(0, 0, 1, 8'h33, 0, "R3 after reset ack");
    chk("R3 data0 stored", csr_ctl, 8'h03);
    wr_csr(0, 8'h01);

    // R5: error packet in bulk (expected DATA1)
    send_pkt(1, 1, 2, 8'h34, -1, "R5");
    chk("R5 not stored", csr_ctl, 8'h00);

    // R6: stall
    wr_csr(0, 8'h20);
    send_pkt(1, 0, 2, 8'h36, 2, "R6 stall");
    chk("R6 ctl", csr_ctl, 8'h30);
    chk("R11 irq on stall", irq, 1);
    wr_csr(0, 8'h10);
    chk("R6 cleared", csr_ctl, 8'h00);
    send_pkt(1, 0, 1, 8'h38, 0, "R6 ack after stall");
    wr_csr(0, 8'h01);

    // R7/R8: isochronous, stall bit ignored, expected toggle DATA0
    wr_csr(1, 8'h01);
    wr_csr(0, 8'h20);
    send_pkt(1, 1, 2, 8'h40, -1, "R7 iso err");
    chk("R7 stored with error", csr_ctl, 8'h27);
    send_pkt(0, 0, 2, 8'h42, -1, "R8 iso full");
    chk("R8 overrun", csr_ctl, 8'h2F);
    wr_csr(0, 8'h21);
    chk("R7 error cleared with release", csr_ctl, 8'h28);
    wr_csr(0, 8'h08);
    chk("R8 overrun cleared", csr_ctl, 8'h00);

    // R9: double buffering, expected DATA0
    wr_csr(1, 8'h02);
    send_pkt(0, 0, 2, 8'h50, 0, "R9 first ack");
    chk("R9 one held not full", csr_ctl, 8'h01);
    send_pkt(1, 0, 3, 8'h60, 0, "R9 second ack");
    chk("R9 two held full", csr_ctl, 8'h03);
    send_pkt(0, 0, 1, 8'h70, 1, "R9 nak when two held");
    rd_byte(8'h50, "R9 oldest first");
    wr_csr(0, 8'h40);
    chk("R9 one left", csr_ctl, 8'h01);
    chk("R9 next len", fifo_len, 3);
    chk("R9 restart at byte0", fifo_rdata, 8'h60);
    wr_csr(0, 8'h40);
    chk("R9 empty", csr_ctl, 8'h00);

    // R10: auto-release, max 4, expected DATA0
    wr_csr(1, 8'h04);
    send_pkt(0, 0, 4, 8'h80, 0, "R10 max ack");
    for (int i = 0; i < 4; i++) rd_byte(8'h80 + i, "R10 max byte");
    chk("R10 auto released", csr_ctl, 8'h00);
    send_pkt(1, 0, 2, 8'h90, 0, "R10 short ack");
    rd_byte(8'h90, "R10 short byte");
    rd_byte(8'h91, "R10 short byte");
    chk("R10 short kept", csr_ctl, 8'h03);
    wr_csr(0, 8'h01);

    // R13
    wr_csr(1, 8'hFF);
    chk("R13 cfg reserved", csr_cfg, 8'h07);
    wr_csr(1, 8'h00);
    wr_csr(0, 8'hC0);
    chk("R13 ctl self-clearing", csr_ctl, 8'h00);

    @(negedge clk);
    chk("R2 scoreboard drained", exp_code.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule